// File: doc/BRIEF.md
# Software Interrupt Pending Register

This block keeps a 17-bit register of pending software interrupt requests and a 4-bit current interrupt level for one processor core. From these two values it produces one registered request line for each pending bit. The core's register decode reaches the block over a small bus of write enable, address and data. Three addresses change the pending bits: one replaces the whole value, one sets bits, and one clears bits. A fourth address loads the interrupt level. A read select returns either the pending bits or the level.

Two bits are reserved for timer matches. Bit 0 reports a tick-timer match and bit 16 a system-timer match. These two bits are masked by a fixed level threshold, not by their own index. Timer-compare units assert one-cycle hit pulses, and each pulse sets bit 16 without touching the other pending bits. A hit takes priority over any software write to the pending bits in the same cycle. Trap vectoring, acknowledge and privilege checks belong to other blocks.

Top module: `swint_ctrl`

## Requirements
- R1: While reset (rst_n low) is asserted, the pending bits, the level and every request output are zero.
- R2: A write with reg_addr = 0 replaces all 17 pending bits with reg_wdata.
- R3: A write with reg_addr = 1 ORs reg_wdata into the pending bits.
- R4: A write with reg_addr = 2 clears each pending bit whose reg_wdata bit is 1 and keeps every other bit.
- R5: A write with reg_addr = 3 loads reg_wdata[3:0] into the level. It leaves the pending bits unchanged.
- R6: For index i from 1 to 15, irq_req[i] is 1 exactly when pending bit i is 1 and i is strictly greater than the level.
- R7: irq_req[0] and irq_req[16] are each 1 exactly when the matching pending bit is 1 and the level is below 14.
- R8: A cycle with any tmr_hit bit high sets pending bit 16 and preserves all other pending bits.
- R9: When a timer hit and a software pending write (reg_addr 0, 1 or 2) fall in the same cycle, pending bit 16 ends up 1 whatever the write data. The write still applies to bits 15 to 0.
- R10: irq_req is registered. It changes at the clock edge that samples the write or hit and never earlier.
- R11: rd_data is combinational. It shows the pending bits when rd_sel = 0, and the level zero-extended to 17 bits when rd_sel = 1.
- R12: In a cycle with reg_we low and no timer hit, the pending bits and the level keep their values whatever reg_addr and reg_wdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write enable |
| reg_addr | input | 2 | Write address: 0 replace, 1 set, 2 clear, 3 level |
| reg_wdata | input | 17 | Write data |
| tmr_hit | input | 2 | One-cycle match pulses from the timer-compare units |
| rd_sel | input | 1 | Readback select: 0 pending bits, 1 level |
| rd_data | output | 17 | Readback data |
| irq_req | output | 17 | Per-bit interrupt requests |

## Verification
Writes and timer hits are sampled at a rising edge. The pending bits, the level, the readback and irq_req all show the new value right after that edge, so each result is due one cycle after its stimulus. The bench drives every input at a falling edge and holds it across exactly one rising edge. It then compares at the next falling edge, once everything has settled. For the registered-output requirement, it also compares irq_req at the falling edge where a level change is first driven, to show that nothing moves before the edge. The level sweeps cover all 16 values against several pending patterns, with expected requests computed bit by bit in the bench.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int PEND_W   = 17;
  localparam int LVL_W    = 4;
  localparam int ADDR_W   = 2;
  localparam int LVL_GATE = 14;
  localparam int TOP_BIT  = PEND_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_LVL  = 2'd3
  } op_e;

  // apply a software operation to the pending value
  function automatic logic [PEND_W-1:0] apply_sw(
    input logic [PEND_W-1:0] cur,
    input op_e               op,
    input logic [PEND_W-1:0] data
  );
    case (op)
      OP_LOAD: apply_sw = data;
      OP_SET:  apply_sw = cur | data;
      OP_CLR:  apply_sw = cur & ~data;
      default: apply_sw = cur;
    endcase
  endfunction

  // does one pending bit at index idx pass the level mask
  function automatic logic bit_passes(
    input int               idx,
    input logic [LVL_W-1:0] lvl
  );
    if (idx == 0 || idx == TOP_BIT)
      bit_passes = (int'(lvl) < LVL_GATE);
    else
      bit_passes = (idx > int'(lvl));
  endfunction
endpackage

// File: rtl/swint_next.sv
module swint_next
  import swint_pkg::*;
#(
  parameter int HW_SRC = 2
) (
  input  logic [PEND_W-1:0] pend_q,
  input  logic [LVL_W-1:0]  lvl_q,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PEND_W-1:0] wdata,
  input  logic [HW_SRC-1:0] hit,
  output logic [PEND_W-1:0] pend_d,
  output logic [LVL_W-1:0]  lvl_d,
  output logic              sw_pend_ev,
  output logic              lvl_ev,
  output logic              hw_ev
);
  op_e op;
  logic [PEND_W-1:0] after_sw;

  assign op         = op_e'(addr);
  assign hw_ev      = |hit;
  assign lvl_ev     = we && (op == OP_LVL);
  assign sw_pend_ev = we && (op != OP_LVL);

  always_comb begin
    after_sw = sw_pend_ev ? apply_sw(pend_q, op, wdata) : pend_q;
    pend_d   = after_sw;
    if (hw_ev) pend_d[TOP_BIT] = 1'b1;
  end

  assign lvl_d = lvl_ev ? wdata[LVL_W-1:0] : lvl_q;
endmodule

// File: rtl/swint_gate.sv
module swint_gate
  import swint_pkg::*;
(
  input  logic [PEND_W-1:0] pend,
  input  logic [LVL_W-1:0]  lvl,
  output logic [PEND_W-1:0] req
);
  for (genvar i = 0; i < PEND_W; i++) begin : g_bit
    assign req[i] = pend[i] && bit_passes(i, lvl);
  end
endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int HW_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [16:0]       reg_wdata,
  input  logic [HW_SRC-1:0] tmr_hit,
  input  logic              rd_sel,
  output logic [16:0]       rd_data,
  output logic [16:0]       irq_req
);
  logic [PEND_W-1:0] pend_q, pend_d, req_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              sw_pend_ev, lvl_ev, hw_ev;

  swint_next #(.HW_SRC(HW_SRC)) u_next (
    .pend_q     (pend_q),
    .lvl_q      (lvl_q),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .hit        (tmr_hit),
    .pend_d     (pend_d),
    .lvl_d      (lvl_d),
    .sw_pend_ev (sw_pend_ev),
    .lvl_ev     (lvl_ev),
    .hw_ev      (hw_ev)
  );

  // requests follow the next state so they land on the same edge
  swint_gate u_gate (
    .pend (pend_d),
    .lvl  (lvl_d),
    .req  (req_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      lvl_q   <= '0;
      irq_req <= '0;
    end else begin
      pend_q  <= pend_d;
      lvl_q   <= lvl_d;
      irq_req <= req_d;
    end
  end

  assign rd_data = rd_sel ? {{(PEND_W-LVL_W){1'b0}}, lvl_q} : pend_q;
endmodule

// File: rtl/swint_ctrl_chk.sv
module swint_ctrl_chk
  import swint_pkg::*;
#(
  parameter int HW_SRC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [16:0]       reg_wdata,
  input logic [HW_SRC-1:0] tmr_hit,
  input logic [16:0]       irq_req,
  input logic [PEND_W-1:0] pend_q,
  input logic [LVL_W-1:0]  lvl_q
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pend_q == '0 && lvl_q == '0 && irq_req == '0));

  a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=> ((pend_q & $past(reg_wdata)) == $past(reg_wdata)));

  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd2) |=> ((pend_q[15:0] & $past(reg_wdata[15:0])) == '0));

  a_r6_need_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~pend_q) == '0));

  a_r7_timer_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl_q) >= LVL_GATE) |-> (!irq_req[0] && !irq_req[16]));

  a_r8_hit_sets_top: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_hit) |=> pend_q[16]);

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && !(|tmr_hit)) |=> ($stable(pend_q) && $stable(lvl_q)));
endmodule

bind swint_ctrl swint_ctrl_chk #(.HW_SRC(HW_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tmr_hit   (tmr_hit),
  .irq_req   (irq_req),
  .pend_q    (pend_q),
  .lvl_q     (lvl_q)
);

// File: tb/test_swint_ctrl.sv
module test_swint_ctrl;
  localparam int CLK_HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [16:0] reg_wdata = '0;
  logic [1:0]  tmr_hit = '0;
  logic        rd_sel = 1'b0;
  logic [16:0] rd_data, irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  swint_ctrl i_swint_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tmr_hit(tmr_hit), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_req(irq_req)
  );

  function automatic logic [16:0] model_req(input logic [16:0] p, input int lvl);
    logic [16:0] r = '0;
    for (int i = 0; i < 17; i++) begin
      if (i == 0 || i == 16) r[i] = p[i] && (lvl < 14);
      else                   r[i] = p[i] && (i > lvl);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  // one write across one rising edge; returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [16:0] d, input logic [1:0] h);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; tmr_hit = h;
    @(negedge clk);
    reg_we = 1'b0; tmr_hit = '0;
  endtask

  task automatic hit_only(input logic [1:0] h);
    tmr_hit = h;
    @(negedge clk);
    tmr_hit = '0;
  endtask

  task automatic rd_pend(output logic [16:0] v);
    rd_sel = 1'b0; #1 v = rd_data;
  endtask

  task automatic rd_lvl(output logic [16:0] v);
    rd_sel = 1'b1; #1 v = rd_data; rd_sel = 1'b0;
  endtask

  initial begin
    logic [16:0] v;
    logic [16:0] pats [5];
    pats[0] = 17'h1FFFF; pats[1] = 17'h10001; pats[2] = 17'h0AAAA;
    pats[3] = 17'h15555; pats[4] = 17'h08000;

    @(negedge clk); @(negedge clk);
    check("R1 irq in reset", irq_req, '0);
    rd_pend(v); check("R1 pending in reset", v, '0);
    rd_lvl(v);  check("R1 level in reset", v, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: level load, pending untouched
    wr(2'd0, 17'h00123, 2'b00);
    wr(2'd3, 17'h1FFF3, 2'b00);
    rd_lvl(v);  check("R5 level loaded", v, 17'h3);
    rd_pend(v); check("R5 pending kept", v, 17'h00123);

    // R2, R6, R7: sweep patterns over all levels
    foreach (pats[k]) begin
      wr(2'd0, pats[k], 2'b00);
      rd_pend(v); check("R2 direct replace", v, pats[k]);
      for (int l = 0; l < 16; l++) begin
        wr(2'd3, 17'(l), 2'b00);
        check("R6/R7 level mask", irq_req, model_req(pats[k], l));
      end
    end

    // R3 set, R4 clear
    wr(2'd3, 17'h0, 2'b00);
    wr(2'd0, 17'h00005, 2'b00);
    wr(2'd1, 17'h10100, 2'b00);
    rd_pend(v); check("R3 set alias", v, 17'h10105);
    check("R3 requests", irq_req, model_req(17'h10105, 0));
    wr(2'd2, 17'h00101, 2'b00);
    rd_pend(v); check("R4 clear alias", v, 17'h10004);

    // R8 timer hits
    wr(2'd0, 17'h00004, 2'b00);
    hit_only(2'b01);
    rd_pend(v); check("R8 hit unit0", v, 17'h10004);
    wr(2'd0, 17'h00810, 2'b00);
    hit_only(2'b10);
    rd_pend(v); check("R8 hit unit1", v, 17'h10810);
    check("R8 requests", irq_req, model_req(17'h10810, 0));

    // R9 hit beats clear and load
    wr(2'd0, 17'h1FFFF, 2'b00);
    wr(2'd2, 17'h1FFFF, 2'b01);
    rd_pend(v); check("R9 hit over clear", v, 17'h10000);
    wr(2'd0, 17'h00007, 2'b10);
    rd_pend(v); check("R9 hit over load", v, 17'h10007);

    // R10 registered output
    wr(2'd0, 17'h1FFFF, 2'b00);
    wr(2'd3, 17'h0, 2'b00);
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 17'hF;
    #1 check("R10 no change before edge", irq_req, model_req(17'h1FFFF, 0));
    @(negedge clk);
    reg_we = 1'b0;
    check("R10 change after edge", irq_req, model_req(17'h1FFFF, 15));

    // R11 readback select, R12 idle hold
    rd_lvl(v); check("R11 level readback", v, 17'hF);
    reg_addr = 2'd0; reg_wdata = 17'h0;
    @(negedge clk);
    reg_addr = 2'd2; reg_wdata = 17'h1FFFF;
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = 17'h00002;
    @(negedge clk);
    rd_pend(v); check("R12 pending held", v, 17'h1FFFF);
    rd_lvl(v);  check("R12 level held", v, 17'hF);
    check("R12 requests held", irq_req, model_req(17'h1FFFF, 15));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule